// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block turns single internal read or write requests into timed cycles on an external memory bus. On that bus the low address byte and the data byte share one 8-bit port, and the upper fourteen address bits have lines of their own. The block drives an address-latch strobe, an active-low read strobe and an active-low write strobe. It places each edge on a phase tick that runs at twice the bus clock rate, so one tick is half a bus clock. Every edge of the bus cycle therefore lands on a whole tick.

Two wait-state counts, each 0 to 7, stretch the cycle. The address count lengthens the time the latch strobe is high. The data count lengthens the time the read or write strobe is low. Both counts are sampled when a request is accepted. A full cycle lasts 2·Wa + 2·Wd + 4 ticks: the latch-high window, one address-hold tick, the strobe window, and one turnaround tick.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so it stays low from acceptance until the turnaround tick has ended. While `req_ready` is low, the requester must keep `req_valid` and the request fields steady. The response side has no back-pressure: `rsp_valid` pulses for one tick and must be taken on that tick.

Top module: `mxb_cycle_gen`

## Requirements
- R1: After reset, `bus_ale` is 0, `bus_oe_n` and `bus_we_n` are 1, `bus_ad_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Let tick 0 be the first tick after acceptance. `bus_ale` is high on ticks 0 to 2·Wa and low on every other tick of the cycle.
- R3: On ticks 0 to 2·Wa+1, `bus_ad_oe` is 1 and `bus_ad_out` carries request address bits [7:0]. This covers the latch-high window and the one tick after the latch strobe falls.
- R4: The strobe is low on ticks 2·Wa+2 to 2·Wa+2·Wd+2, which is 2·Wd+1 ticks. It rises 2·(Wa+Wd)+3 ticks after the latch strobe rose. A read (`req_write`=0) uses `bus_oe_n`; a write uses `bus_we_n`.
- R5: On a read, `bus_ad_oe` is 0 from the tick the read strobe falls through the tick after it rises.
- R6: On a write, `bus_ad_oe` is 1 and `bus_ad_out` carries the write data from the tick the write strobe falls through the tick after it rises.
- R7: `bus_addr_hi` equals request address bits [21:8] and stays unchanged for the whole cycle.
- R8: On a read, the value on `bus_ad_in` during the last strobe-low tick is captured. That value appears on `rsp_rdata` while `rsp_valid` is high.
- R9: `rsp_valid` is high for exactly one tick per cycle, on tick 2·Wa+2·Wd+3. `req_ready` is low on every tick of the cycle and high again on the next tick. A request held valid during a cycle is not taken until then.
- R10: Changes to `wa_cfg` or `wd_cfg` after acceptance do not alter the timing of the cycle in progress.
- R11: The two strobes are never low together, and neither is low while `bus_ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase tick clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wa_cfg | input | 3 | Address-phase wait states, sampled at acceptance |
| wd_cfg | input | 3 | Data-phase wait states, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 22 | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-tick completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr_hi | output | 14 | Dedicated upper address lines |
| bus_ad_out | output | 8 | Value driven onto the shared port |
| bus_ad_oe | output | 1 | Drive enable for the shared port |
| bus_ad_in | input | 8 | Value seen on the shared port |

## Verification
The assertions check these rules on every tick:
- the latch-high and strobe-low run lengths against the sampled wait counts;
- strobe exclusivity;
- release of the shared port during a read;
- the write data still being driven on the tick after the write strobe rises;
- the upper address staying stable while busy;
- the one-tick response pulse.

The bench sweeps every pair of wait counts for both reads and writes and compares each pin on each tick against tick positions computed by arithmetic. Only that sweep shows four things: the exact absolute tick placement, the address and data values on the port, which tick's input value is captured, and that mid-cycle changes to the wait counts are ignored.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_LATCH  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;
endpackage

// File: rtl/mxb_span_counter.sv
module mxb_span_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mxb_pin_drive.sv
module mxb_pin_drive
  import mxb_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              wr,
  input  logic [PORT_W-1:0] addr_lo,
  input  logic [PORT_W-1:0] wdata,
  output logic              ale,
  output logic              oe_n,
  output logic              we_n,
  output logic              ad_oe,
  output logic [PORT_W-1:0] ad_out
);
  logic addr_on_port;
  logic data_on_port;

  always_comb begin
    addr_on_port = (phase == PH_ADDR) || (phase == PH_LATCH);
    data_on_port = wr && ((phase == PH_STROBE) || (phase == PH_HOLD));
    ale    = (phase == PH_ADDR);
    oe_n   = !((phase == PH_STROBE) && !wr);
    we_n   = !((phase == PH_STROBE) && wr);
    ad_oe  = addr_on_port || data_on_port;
    ad_out = addr_on_port ? addr_lo : wdata;
  end

  // R11: strobes never overlap each other or the latch window
  a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((!oe_n && !we_n) || (ale && (!oe_n || !we_n))));

  // R5: shared port released while read strobe is low and on the tick after
  a_r5_read_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || $rose(oe_n)) |-> !ad_oe);

  // R6: write data still driven, unchanged, on the tick after the write strobe rises
  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (ad_oe && $stable(ad_out)));

  // R3: low address byte still on the port on the tick after the latch falls
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));
endmodule

// File: rtl/mxb_read_capture.sv
module mxb_read_capture #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [PORT_W-1:0] d_in,
  output logic [PORT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= d_in;
  end
endmodule

// File: rtl/mxb_cycle_gen.sv
module mxb_cycle_gen
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int PORT_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WAIT_W-1:0]        wa_cfg,
  input  logic [WAIT_W-1:0]        wd_cfg,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [PORT_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [PORT_W-1:0]        rsp_rdata,
  output logic                     bus_ale,
  output logic                     bus_oe_n,
  output logic                     bus_we_n,
  output logic [ADDR_W-PORT_W-1:0] bus_addr_hi,
  output logic [PORT_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [PORT_W-1:0]        bus_ad_in
);
  localparam int HI_W  = ADDR_W - PORT_W;
  localparam int CNT_W = WAIT_W + 1;

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q;
  logic [PORT_W-1:0] wdata_q;
  logic              wr_q;
  logic [WAIT_W-1:0] wa_q, wd_q;
  logic              accept, span_zero, span_load;
  logic [CNT_W-1:0]  span_val;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_d   = phase_q;
    span_load = 1'b0;
    span_val  = {wa_cfg, 1'b0};
    unique case (phase_q)
      PH_IDLE:   if (accept) begin
                   phase_d   = PH_ADDR;
                   span_load = 1'b1;
                 end
      PH_ADDR:   if (span_zero) phase_d = PH_LATCH;
      PH_LATCH:  begin
                   phase_d   = PH_STROBE;
                   span_load = 1'b1;
                   span_val  = {wd_q, 1'b0};
                 end
      PH_STROBE: if (span_zero) phase_d = PH_HOLD;
      PH_HOLD:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        wa_q    <= wa_cfg;
        wd_q    <= wd_cfg;
      end
    end
  end

  mxb_span_counter #(.CNT_W(CNT_W)) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (span_load),
    .load_val (span_val),
    .zero     (span_zero)
  );

  mxb_pin_drive #(.PORT_W(PORT_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase_q),
    .wr      (wr_q),
    .addr_lo (addr_q[PORT_W-1:0]),
    .wdata   (wdata_q),
    .ale     (bus_ale),
    .oe_n    (bus_oe_n),
    .we_n    (bus_we_n),
    .ad_oe   (bus_ad_oe),
    .ad_out  (bus_ad_out)
  );

  mxb_read_capture #(.PORT_W(PORT_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture ((phase_q == PH_STROBE) && span_zero && !wr_q),
    .d_in    (bus_ad_in),
    .q       (rsp_rdata)
  );

  assign rsp_valid   = (phase_q == PH_HOLD);
  assign bus_addr_hi = addr_q[ADDR_W-1:PORT_W];

  // Run-length counters feeding the window checks below
  logic [CNT_W:0] ale_run, stb_run;
  logic           stb_low;
  assign stb_low = !bus_oe_n || !bus_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_run <= '0;
      stb_run <= '0;
    end else begin
      ale_run <= bus_ale ? ale_run + 1'b1 : '0;
      stb_run <= stb_low ? stb_run + 1'b1 : '0;
    end
  end

  // R2: latch strobe high for 2*Wa+1 ticks
  a_r2_ale_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (ale_run == ({1'b0, wa_q, 1'b0} + 1'b1)));

  // R4: strobe low for 2*Wd+1 ticks
  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_low) |-> (stb_run == ({1'b0, wd_q, 1'b0} + 1'b1)));

  // R7: upper address steady while a cycle is running
  a_r7_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(bus_addr_hi));

  // R9: completion pulse lasts one tick and is followed by idle
  a_r9_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: tb/mxb_cycle_gen_tb.sv
module mxb_cycle_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wa_cfg = '0, wd_cfg = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, rsp_rdata, bus_ad_out, bus_ad_in = '0;
  logic        bus_ale, bus_oe_n, bus_we_n, bus_ad_oe;
  logic [13:0] bus_addr_hi;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mxb_cycle_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wa_cfg(wa_cfg), .wd_cfg(wd_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_ale(bus_ale), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
  );

  task automatic chk(input bit ok, input string tag, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s tick %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic run_txn(input int wa, input int wd, input bit wr,
                         input logic [21:0] addr, input logic [7:0] data);
    int total, s_first, s_last;
    logic [7:0] cap_exp;
    total   = 2*wa + 2*wd + 4;
    s_first = 2*wa + 2;
    s_last  = 2*wa + 2*wd + 2;
    cap_exp = data ^ 8'(s_last * 7);
    @(negedge clk);
    wa_cfg = 3'(wa); wd_cfg = 3'(wd);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    @(posedge clk);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k == 0) begin
        wa_cfg = ~3'(wa); wd_cfg = ~3'(wd);   // R10: must not matter now
      end
      if (k == total - 1) req_valid = 1'b0;   // R9: held valid while busy
      bus_ad_in = data ^ 8'(k * 7);
      begin
        bit e_ale, e_stb, e_oe, e_addr;
        e_ale  = (k <= 2*wa);
        e_stb  = (k >= s_first) && (k <= s_last);
        e_addr = (k <= 2*wa + 1);
        e_oe   = e_addr || (wr && k >= s_first);
        chk(bus_ale == e_ale, "R2 ale", k, 32'(bus_ale), 32'(e_ale));
        chk(bus_oe_n == !(e_stb && !wr), "R4 oe_n", k, 32'(bus_oe_n), 32'(!(e_stb && !wr)));
        chk(bus_we_n == !(e_stb && wr), "R4 we_n", k, 32'(bus_we_n), 32'(!(e_stb && wr)));
        chk(bus_ad_oe == e_oe, wr ? "R6 port drive" : "R5 port drive", k,
            32'(bus_ad_oe), 32'(e_oe));
        if (e_addr)
          chk(bus_ad_out == addr[7:0], "R3 addr low", k, 32'(bus_ad_out), 32'(addr[7:0]));
        else if (wr)
          chk(bus_ad_out == data, "R6 wdata", k, 32'(bus_ad_out), 32'(data));
        chk(bus_addr_hi == addr[21:8], "R7 addr hi", k, 32'(bus_addr_hi), 32'(addr[21:8]));
        chk(req_ready == 1'b0, "R9 ready busy", k, 32'(req_ready), 32'd0);
        chk(rsp_valid == (k == total - 1), "R9 rsp_valid", k,
            32'(rsp_valid), 32'(k == total - 1));
        if (!wr && k == total - 1)
          chk(rsp_rdata == cap_exp, "R8 rdata", k, 32'(rsp_rdata), 32'(cap_exp));
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready idle", total, 32'(req_ready), 32'd1);
    chk(!bus_ale && bus_oe_n && bus_we_n && !bus_ad_oe && !rsp_valid,
        "R11 idle pins", total, {bus_ale, bus_oe_n, bus_we_n, bus_ad_oe, rsp_valid}, 32'b01100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bus_ale && bus_oe_n && bus_we_n && !bus_ad_oe && !rsp_valid && req_ready,
        "R1 reset", 0, {bus_ale, bus_oe_n, bus_we_n, bus_ad_oe, rsp_valid, req_ready},
        32'b011001);
    rst_n = 1'b1;
    for (int wa = 0; wa < 8; wa++)
      for (int wd = 0; wd < 8; wd++)
        for (int wr = 0; wr < 2; wr++) begin
          int idx;
          idx = wa*16 + wd*2 + wr;
          run_txn(wa, wd, wr[0], 22'h2A5C3 ^ 22'(idx * 22'h1357), 8'hA5 ^ 8'(idx * 3));
        end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule